// File: doc/BRIEF.md
# DMA Transfer Sequencer

This block moves data for one DMA channel that has already been granted the bus. A run is started by the channel request line. The run follows one of four modes, and each mode has its own rule for when the run stops. Each word that a peripheral moves to memory takes one write cycle. Each memory-to-memory word takes a read cycle and then a write cycle. Between those two cycles the word is held in a temporary data register, and that register keeps its value once the run is over.

The start addresses, the word count and the mode are static inputs. They are sampled only when a fresh run begins, which means after reset or after a run has ended through terminal count or end-of-process. A run that stops for any other reason keeps its address, count and mode, and the next request resumes it. This gives the rule that the channel may be reprogrammed only while it is idle with no run in progress. Arbitration with the host processor, cascading and register decode live outside this block.

Top module: `dma_xfer_seq`

## Requirements
- R1: While reset is held and after it is released, idle_o is 1, ack_o, mem_rd_o, mem_wr_o and tc_o are 0, and data_o is 0.
- R2: mode_i selects the mode: 0 single, 1 block, 2 demand, 3 memory-to-memory. With idle_o high and req_i high at a clock edge, the first bus cycle is driven in the next cycle. mode_i, src_addr_i, dst_addr_i and count_i are sampled only at the start of a fresh run, which is the first start after reset or after a run that ended by terminal count or end-of-process. Changes to these inputs at any other time are ignored.
- R3: In single mode, each request moves exactly one word and the block then returns to idle. The next request continues at the next address with the remaining count.
- R4: In block mode, one request moves words on consecutive cycles until terminal count or end-of-process, whatever req_i does after the start.
- R5: In demand mode, words are moved as long as req_i stays high. When req_i is low at the end of a word's write cycle, that word is the last one and the block goes idle. A later request resumes where the run left off.
- R6: A run moves count_i+1 words. tc_o is high during the write cycle of the last word, and the block is idle in the cycle after it.
- R7: If eop_n_i is low during a write cycle, that word completes and the run ends without tc_o. The next request starts a fresh run. A low eop_n_i while the block is idle has no effect.
- R8: The destination address starts at dst_addr_i and increases by one after each word. The source address starts at src_addr_i and increases by one after each memory-to-memory read. Outside memory-to-memory mode, addr_o carries the destination address.
- R9: In memory-to-memory mode, each word is a read cycle (mem_rd_o, addr_o = source) followed at once by a write cycle (mem_wr_o, addr_o = destination, data_o = the word read from rd_data_i).
- R10: data_o shows the temporary register. It changes only at the end of a memory-to-memory read cycle. It keeps the last word moved until reset, and runs in other modes leave it unchanged.
- R11: mem_rd_o and mem_wr_o are never high together, and ack_o is high exactly when one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Transfer mode (0 single, 1 block, 2 demand, 3 memory-to-memory) |
| src_addr_i | input | AW | Start source address for memory-to-memory runs |
| dst_addr_i | input | AW | Start destination address |
| count_i | input | CW | Word count minus one |
| req_i | input | 1 | Channel request |
| eop_n_i | input | 1 | External end-of-process, active low |
| rd_data_i | input | DW | Memory read data |
| ack_o | output | 1 | Channel acknowledge |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_o | output | AW | Bus address |
| data_o | output | DW | Temporary register, used as write data in memory-to-memory mode |
| tc_o | output | 1 | Terminal count, high during the last word |
| idle_o | output | 1 | No bus cycle in progress |

## Verification
The hardest case to reach from the ports is a run that is still in progress while the block is idle. This happens between single-mode requests and after a demand run has been paused. In that state, new programming values and a stray end-of-process must both be ignored. The stimulus pauses a run in each of these two ways, changes the start inputs and pulses eop_n_i while the block is idle, and then expects the addresses and terminal count to continue from the paused run. A scoreboard lists every expected bus cycle in advance, so a word that is lost, added or put at the wrong address shows up as a mismatch.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BLOCK  = 2'd1,
    MODE_DEMAND = 2'd2,
    MODE_M2M    = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          src_inc_i,
  input  logic          dst_inc_i,
  input  logic          cnt_dec_i,
  input  logic [AW-1:0] src_init_i,
  input  logic [AW-1:0] dst_init_i,
  input  logic [CW-1:0] cnt_init_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          cnt_zero_o
);
  localparam int NPTR = 2;
  localparam int PSRC = 0;
  localparam int PDST = 1;

  logic [AW-1:0] ptr_init [NPTR];
  logic          ptr_inc  [NPTR];
  logic [AW-1:0] ptr_q    [NPTR];
  logic [CW-1:0] cnt_q, cnt_d;

  assign ptr_init[PSRC] = src_init_i;
  assign ptr_init[PDST] = dst_init_i;
  assign ptr_inc[PSRC]  = src_inc_i;
  assign ptr_inc[PDST]  = dst_inc_i;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    logic [AW-1:0] ptr_d;
    logic          ptr_en;

    always_comb begin
      ptr_en = load_i | ptr_inc[p];
      ptr_d  = load_i ? ptr_init[p] : ptr_q[p] + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q[p] <= '0;
      else if (ptr_en) ptr_q[p] <= ptr_d;
    end
  end

  always_comb begin
    cnt_d = load_i ? cnt_init_i : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load_i || cnt_dec_i) cnt_q <= cnt_d;
  end

  assign src_o      = ptr_q[PSRC];
  assign dst_o      = ptr_q[PDST];
  assign cnt_zero_o = (cnt_q == '0);
endmodule

// File: rtl/dma_temp_reg.sv
module dma_temp_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (cap_i) word_q <= d_i;
  end

  assign q_o = word_q;
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       req_i,
  input  logic       eop_n_i,
  input  logic       cnt_zero_i,
  output logic       load_o,
  output logic       src_inc_o,
  output logic       dst_inc_o,
  output logic       cnt_dec_o,
  output logic       cap_o,
  output logic       ack_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic       use_src_o,
  output logic       tc_o,
  output logic       idle_o
);
  seq_state_e state_q, state_d;
  xfer_mode_e mode_q, mode_d, eff_mode;
  logic       run_q, run_d;
  logic       last_word;

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    run_d     = run_q;
    load_o    = 1'b0;
    src_inc_o = 1'b0;
    dst_inc_o = 1'b0;
    cnt_dec_o = 1'b0;
    cap_o     = 1'b0;
    eff_mode  = run_q ? mode_q : xfer_mode_e'(mode_i);
    last_word = cnt_zero_i || !eop_n_i;

    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (!run_q) begin
            load_o = 1'b1;
            run_d  = 1'b1;
            mode_d = xfer_mode_e'(mode_i);
          end
          state_d = (eff_mode == MODE_M2M) ? ST_RD : ST_XFER;
        end
      end
      ST_XFER: begin
        dst_inc_o = 1'b1;
        cnt_dec_o = 1'b1;
        if (last_word) begin
          state_d = ST_IDLE;
          run_d   = 1'b0;
        end else begin
          unique case (mode_q)
            MODE_BLOCK:  state_d = ST_XFER;
            MODE_DEMAND: state_d = req_i ? ST_XFER : ST_IDLE;
            default:     state_d = ST_IDLE;
          endcase
        end
      end
      ST_RD: begin
        src_inc_o = 1'b1;
        cap_o     = 1'b1;
        state_d   = ST_WR;
      end
      ST_WR: begin
        dst_inc_o = 1'b1;
        cnt_dec_o = 1'b1;
        if (last_word) begin
          state_d = ST_IDLE;
          run_d   = 1'b0;
        end else begin
          state_d = ST_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_SINGLE;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      if (load_o) mode_q <= mode_d;
    end
  end

  assign ack_o     = (state_q != ST_IDLE);
  assign rd_o      = (state_q == ST_RD);
  assign wr_o      = (state_q == ST_XFER) || (state_q == ST_WR);
  assign use_src_o = (state_q == ST_RD);
  assign tc_o      = wr_o && cnt_zero_i;
  assign idle_o    = (state_q == ST_IDLE);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          req_i,
  input  logic          eop_n_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          ack_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          tc_o,
  output logic          idle_o
);
  logic          rst_int_n;
  logic          load, src_inc, dst_inc, cnt_dec, cap, use_src, cnt_zero;
  logic [AW-1:0] src_q, dst_q;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dma_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode_i     (mode_i),
    .req_i      (req_i),
    .eop_n_i    (eop_n_i),
    .cnt_zero_i (cnt_zero),
    .load_o     (load),
    .src_inc_o  (src_inc),
    .dst_inc_o  (dst_inc),
    .cnt_dec_o  (cnt_dec),
    .cap_o      (cap),
    .ack_o      (ack_o),
    .rd_o       (mem_rd_o),
    .wr_o       (mem_wr_o),
    .use_src_o  (use_src),
    .tc_o       (tc_o),
    .idle_o     (idle_o)
  );

  dma_addr_cnt #(.AW(AW), .CW(CW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load),
    .src_inc_i  (src_inc),
    .dst_inc_i  (dst_inc),
    .cnt_dec_i  (cnt_dec),
    .src_init_i (src_addr_i),
    .dst_init_i (dst_addr_i),
    .cnt_init_i (count_i),
    .src_o      (src_q),
    .dst_o      (dst_q),
    .cnt_zero_o (cnt_zero)
  );

  dma_temp_reg #(.DW(DW)) u_temp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cap_i (cap),
    .d_i   (rd_data_i),
    .q_o   (data_o)
  );

  assign addr_o = use_src ? src_q : dst_q;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eop_n_i,
  input logic          ack_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] data_o,
  input logic          tc_o,
  input logic          idle_o
);
  // R11
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));
  // R11
  a_r11_ack_match: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o == (mem_rd_o || mem_wr_o));
  // R9
  a_r9_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (mem_wr_o && !mem_rd_o));
  // R6
  a_r6_tc_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> idle_o);
  // R7
  a_r7_eop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && !eop_n_i) |=> idle_o);
  // R10
  a_r10_temp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_o |=> $stable(data_o));
  // R8
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && !tc_o && eop_n_i) |=> (!mem_wr_o || addr_o == $past(addr_o) + AW'(1)));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eop_n_i  (eop_n_i),
  .ack_o    (ack_o),
  .mem_rd_o (mem_rd_o),
  .mem_wr_o (mem_wr_o),
  .addr_o   (addr_o),
  .data_o   (data_o),
  .tc_o     (tc_o),
  .idle_o   (idle_o)
);

// File: tb/tb_dma_xfer_seq.sv
module tb_dma_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int DW = 8;

  typedef struct {
    logic          is_rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          chk_data;
    logic          tc;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] count;
  logic          req, eop_n;
  logic [DW-1:0] rd_data;
  logic          ack, mem_rd, mem_wr, tc, idle;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return (a[7:0] ^ 8'hA5) + a[15:8];
  endfunction

  assign rd_data = mem_word(addr);

  dma_xfer_seq #(.AW(AW), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .src_addr_i(src_addr),
    .dst_addr_i(dst_addr), .count_i(count), .req_i(req), .eop_n_i(eop_n),
    .rd_data_i(rd_data), .ack_o(ack), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .addr_o(addr), .data_o(data), .tc_o(tc), .idle_o(idle)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic is_rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic cd, input logic t, input string tag);
    exp_t e;
    e.is_rd = is_rd; e.addr = a; e.data = d; e.chk_data = cd; e.tc = t; e.tag = tag;
    q.push_back(e);
  endtask

  // expected words of a peripheral-to-memory stretch
  task automatic push_words(input logic [AW-1:0] dst, input int first, input int n,
                            input int last_idx, input string tag);
    for (int i = first; i < first + n; i++)
      push(1'b0, dst + AW'(i), '0, 1'b0, (i == last_idx), tag);
  endtask

  // monitor: compare every bus cycle with the scoreboard
  always @(negedge clk) begin
    if (rst_n && (mem_rd || mem_wr)) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected bus cycle", longint'(addr), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(mem_rd == e.is_rd && mem_wr == !e.is_rd, {e.tag, " strobe kind"},
              longint'({mem_rd, mem_wr}), longint'({e.is_rd, !e.is_rd}));
        check(addr == e.addr, {e.tag, " address"}, longint'(addr), longint'(e.addr));
        check(tc == e.tc, {e.tag, " terminal count"}, longint'(tc), longint'(e.tc));
        check(ack == 1'b1, "R11 ack with strobe", longint'(ack), 1);
        if (e.chk_data)
          check(data == e.data, {e.tag, " write data"}, longint'(data), longint'(e.data));
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!(idle && q.size() == 0)) @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    while (!ack) @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; src_addr = '0; dst_addr = '0; count = '0;
    req = 1'b0; eop_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(idle && !ack && !mem_rd && !mem_wr && !tc && data == '0, "R1 reset state",
          longint'({idle, ack, mem_rd, mem_wr, tc}), longint'(5'b10000));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(idle && !ack && !tc && data == '0, "R1 after release",
          longint'({idle, ack, tc}), longint'(3'b100));

    // R4 R6 block mode, request dropped after start
    mode = 2'd1; dst_addr = 16'h0100; count = 8'd3;
    push_words(16'h0100, 0, 4, 3, "R4 block");
    pulse_req();
    wait_idle();
    check(idle, "R6 idle after tc", longint'(idle), 1);

    // R3 single mode, with R2 and R7 idle-time disturbances
    mode = 2'd0; dst_addr = 16'h0200; count = 8'd2;
    push_words(16'h0200, 0, 1, 2, "R3 single");
    pulse_req();
    wait_idle();
    check(idle, "R3 idle between requests", longint'(idle), 1);
    dst_addr = 16'h0900; count = 8'd0; mode = 2'd1; // R2 ignored mid-run
    @(negedge clk); eop_n = 1'b0; @(negedge clk); eop_n = 1'b1; // R7 idle eop
    push_words(16'h0200, 1, 1, 2, "R7 R2 single continues");
    pulse_req();
    wait_idle();
    push_words(16'h0200, 2, 1, 2, "R3 R6 single last");
    pulse_req();
    wait_idle();
    mode = 2'd0;
    push(1'b0, 16'h0900, '0, 1'b0, 1'b1, "R2 fresh reload");
    pulse_req();
    wait_idle();

    // R5 demand: pause, reprogram while idle, resume to tc
    mode = 2'd2; dst_addr = 16'h0300; count = 8'd9;
    push_words(16'h0300, 0, 3, 9, "R5 demand first burst");
    @(negedge clk); req = 1'b1;
    for (int k = 0; k < 3; ) begin
      @(negedge clk);
      if (mem_wr) k++;
    end
    req = 1'b0;
    wait_idle();
    check(idle, "R5 idle after request drop", longint'(idle), 1);
    dst_addr = 16'h0A00; count = 8'd1;
    push_words(16'h0300, 3, 7, 9, "R5 demand resumed");
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    while (!tc) @(negedge clk);
    req = 1'b0;
    wait_idle();

    // R7 block stopped by end-of-process, then fresh run
    mode = 2'd1; dst_addr = 16'h0400; count = 8'd7;
    push_words(16'h0400, 0, 3, 99, "R7 eop block");
    @(negedge clk); req = 1'b1;
    for (int k = 0; k < 3; ) begin
      @(negedge clk);
      req = 1'b0;
      if (mem_wr) k++;
    end
    eop_n = 1'b0;
    @(negedge clk);
    eop_n = 1'b1;
    check(idle, "R7 idle after eop", longint'(idle), 1);
    wait_idle();
    dst_addr = 16'h0500; count = 8'd1;
    push_words(16'h0500, 0, 2, 1, "R7 fresh after eop");
    pulse_req();
    wait_idle();

    // R9 R8 memory to memory
    mode = 2'd3; src_addr = 16'h1000; dst_addr = 16'h2000; count = 8'd2;
    for (int i = 0; i < 3; i++) begin
      push(1'b1, 16'h1000 + AW'(i), '0, 1'b0, 1'b0, "R9 m2m read");
      push(1'b0, 16'h2000 + AW'(i), mem_word(16'h1000 + AW'(i)), 1'b1, (i == 2), "R9 R8 m2m write");
    end
    pulse_req();
    wait_idle();
    check(data == mem_word(16'h1002), "R10 temp keeps last word",
          longint'(data), longint'(mem_word(16'h1002)));

    // R10 other mode leaves temp alone
    mode = 2'd1; dst_addr = 16'h0600; count = 8'd0;
    push_words(16'h0600, 0, 1, 0, "R10 block after m2m");
    pulse_req();
    wait_idle();
    check(data == mem_word(16'h1002), "R10 temp after block",
          longint'(data), longint'(mem_word(16'h1002)));
    check(q.size() == 0, "R2 all expected cycles seen", longint'(q.size()), 0);

    // R1 reset clears temp
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(data == '0 && idle, "R1 reset clears temp", longint'(data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule